// File: doc/BRIEF.md
# Learnable Infrared Lamp Toggle Controller

This block sits behind an RC5 infrared frame decoder and drives a single lamp. The decoder hands over each decoded frame as a one-cycle result strobe that carries a 5-bit system address and a 7-bit command. Bit 6 of the command is the key-toggle bit. A separate strobe reports a no-code result, meaning no frame or a broken frame. After every result the controller pulses a request so that the decoder starts another capture.

The controller keeps a reference pair: a system address and a lamp number. These stand in for non-volatile storage. Only a power-on reset restores the defaults, while an ordinary reset keeps whatever was learned. A frame that matches the pair toggles the lamp. After a toggle the controller ignores frames until it sees a no-code result, so a held key acts only once. While the active-low learn button is held, the next valid frame becomes the new reference pair. That same frame is then matched against the new pair, so it also toggles the lamp.

Top module: `rc5_lamp_ctrl`

## Requirements
- R1: While either reset is low, `lamp_no` is high (lamp off) and `req_o` is high.
- R2: In the armed state, a valid frame whose system address equals the stored address and whose masked command equals the stored lamp number inverts `lamp_no` at the clock edge that samples the strobe. A low `lamp_no` means the lamp is on.
- R3: Bit 6 of the command, the toggle bit, is cleared before any store or compare. Only command bits 5:0 take part.
- R4: A valid frame that differs in the system address or in any of command bits 5:0 leaves `lamp_no` unchanged.
- R5: After a toggle, valid frames do not change `lamp_no` until a no-code strobe (`res_fault_i`) has been sampled. That strobe re-arms matching.
- R6: `learn_ni` is active low and passes through a two-stage synchroniser. When it is low in the armed state, a valid frame stores its system address and masked command as the reference pair. The match check of that same frame uses the new pair.
- R7: While the controller waits for a no-code strobe, a low `learn_ni` with a valid frame stores nothing.
- R8: After `por_ni` has been low, the reference pair is system address 0 and lamp number 4.
- R9: A low `rst_ni` alone turns the lamp off and re-arms matching, but keeps the learned pair.
- R10: `req_o` is high in the cycle after any clock edge that samples `res_valid_i` or `res_fault_i`, and is low after an edge that samples neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Ordinary asynchronous reset, active low; keeps the learned pair |
| por_ni | input | 1 | Power-on asynchronous reset, active low; restores the default pair |
| res_valid_i | input | 1 | One-cycle strobe: a decoded frame is on `res_sys_i`/`res_cmd_i` |
| res_fault_i | input | 1 | One-cycle strobe: no-code result |
| res_sys_i | input | 5 | Decoded system address |
| res_cmd_i | input | 7 | Decoded command; bit 6 is the toggle bit |
| learn_ni | input | 1 | Learn button, active low, asynchronous |
| req_o | output | 1 | Decode request pulse |
| lamp_no | output | 1 | Lamp drive, active low (low = on) |

## Verification
The frame patterns are chosen so that each one tells a match apart from a near miss. They cover an exact match of the default pair, the same command with the toggle bit set, and a system address off by one. They also cover a command off in bit 0 and a command differing only in bit 5, which shows that bit 5 is compared while bit 6 is not. Repeated matching frames without a no-code strobe in between separate a single toggle per key press from toggling on every frame. A learn press during the hold phase, followed by a frame carrying the would-be pair, shows whether learning was wrongly accepted. Frames sent after an ordinary reset and after a power-on reset tell the retained pair apart from the restored default.

// File: rtl/rc5_lamp_pkg.sv
package rc5_lamp_pkg;
  typedef enum logic {
    MODE_ARMED = 1'b0,
    MODE_HOLD  = 1'b1
  } mode_e;

  // clear the key-toggle bit (MSB) of a command word
  function automatic logic [6:0] strip_toggle(input logic [6:0] cmd);
    return {1'b0, cmd[5:0]};
  endfunction
endpackage

// File: rtl/rc5l_sync.sv
module rc5l_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[i] <= RST_VAL;
        else if (i == 0) pipe_q[i] <= d_i;
        else pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rc5l_pair_store.sv
module rc5l_pair_store #(
  parameter int unsigned     SYS_W   = 5,
  parameter int unsigned     CMD_W   = 7,
  parameter logic [SYS_W-1:0] DEF_SYS = '0,
  parameter logic [CMD_W-1:0] DEF_NUM = CMD_W'(4)
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             we_i,
  input  logic [SYS_W-1:0] sys_i,
  input  logic [CMD_W-1:0] num_i,
  output logic [SYS_W-1:0] sys_o,
  output logic [CMD_W-1:0] num_o
);
  // only power-on clears: models non-volatile cells
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      sys_o <= DEF_SYS;
      num_o <= DEF_NUM;
    end else if (we_i) begin
      sys_o <= sys_i;
      num_o <= num_i;
    end
  end
endmodule

// File: rtl/rc5l_toggle_fsm.sv
module rc5l_toggle_fsm
  import rc5_lamp_pkg::*;
#(
  parameter int unsigned SYS_W = 5,
  parameter int unsigned CMD_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             fault_i,
  input  logic             learn_i,
  input  logic [SYS_W-1:0] sys_i,
  input  logic [CMD_W-1:0] num_i,
  input  logic [SYS_W-1:0] ref_sys_i,
  input  logic [CMD_W-1:0] ref_num_i,
  output logic             we_o,
  output logic             req_o,
  output logic             lamp_no,
  output logic             hold_o
);
  mode_e mode_q, mode_d;
  logic  frame_ok, hit;
  logic [SYS_W-1:0] cmp_sys;
  logic [CMD_W-1:0] cmp_num;

  assign frame_ok = valid_i && !fault_i;
  assign we_o     = frame_ok && learn_i && (mode_q == MODE_ARMED);
  // a frame being learned is matched against itself
  assign cmp_sys  = we_o ? sys_i : ref_sys_i;
  assign cmp_num  = we_o ? num_i : ref_num_i;
  assign hit      = frame_ok && (mode_q == MODE_ARMED) &&
                    (sys_i == cmp_sys) && (num_i == cmp_num);

  always_comb begin
    mode_d = mode_q;
    if (mode_q == MODE_ARMED) begin
      if (hit) mode_d = MODE_HOLD;
    end else if (fault_i) begin
      mode_d = MODE_ARMED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_ARMED;
      lamp_no <= 1'b1;
      req_o   <= 1'b1;
    end else begin
      mode_q <= mode_d;
      req_o  <= valid_i || fault_i;
      if (hit) lamp_no <= ~lamp_no;
    end
  end

  assign hold_o = (mode_q == MODE_HOLD);
endmodule

// File: rtl/rc5_lamp_ctrl.sv
module rc5_lamp_ctrl
  import rc5_lamp_pkg::*;
#(
  parameter int unsigned SYS_W       = 5,
  parameter int unsigned CMD_W       = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [SYS_W-1:0] DEF_SYS = '0,
  parameter logic [CMD_W-1:0] DEF_NUM = CMD_W'(4)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             res_valid_i,
  input  logic             res_fault_i,
  input  logic [SYS_W-1:0] res_sys_i,
  input  logic [CMD_W-1:0] res_cmd_i,
  input  logic             learn_ni,
  output logic             req_o,
  output logic             lamp_no
);
  logic             rst_all_n, learn_n_s, we_w, hold_w;
  logic [CMD_W-1:0] cmd_m;
  logic [SYS_W-1:0] ref_sys;
  logic [CMD_W-1:0] ref_num;

  assign rst_all_n = rst_ni && por_ni;
  assign cmd_m     = strip_toggle(res_cmd_i);

  rc5l_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_all_n),
    .d_i   (learn_ni),
    .q_o   (learn_n_s)
  );

  rc5l_pair_store #(
    .SYS_W(SYS_W), .CMD_W(CMD_W), .DEF_SYS(DEF_SYS), .DEF_NUM(DEF_NUM)
  ) u_store (
    .clk_i (clk_i),
    .por_ni(por_ni),
    .we_i  (we_w),
    .sys_i (res_sys_i),
    .num_i (cmd_m),
    .sys_o (ref_sys),
    .num_o (ref_num)
  );

  rc5l_toggle_fsm #(.SYS_W(SYS_W), .CMD_W(CMD_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_all_n),
    .valid_i  (res_valid_i),
    .fault_i  (res_fault_i),
    .learn_i  (!learn_n_s),
    .sys_i    (res_sys_i),
    .num_i    (cmd_m),
    .ref_sys_i(ref_sys),
    .ref_num_i(ref_num),
    .we_o     (we_w),
    .req_o    (req_o),
    .lamp_no  (lamp_no),
    .hold_o   (hold_w)
  );
endmodule

// File: rtl/rc5_lamp_ctrl_chk.sv
module rc5_lamp_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_ni,
  input logic res_valid_i,
  input logic res_fault_i,
  input logic req_o,
  input logic lamp_no,
  input logic hold_i
);
  p_req_after_result_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (res_valid_i || res_fault_i) |=> req_o);

  p_req_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !(res_valid_i || res_fault_i) |=> !req_o);

  p_lamp_only_on_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !$stable(lamp_no) |-> $past(res_valid_i && !res_fault_i));

  p_toggle_enters_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !$stable(lamp_no) |-> hold_i);

  p_hold_no_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (hold_i && res_valid_i && !res_fault_i) |=> $stable(lamp_no));

  p_release_on_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (hold_i && res_fault_i) |=> !hold_i);
endmodule

bind rc5_lamp_ctrl rc5_lamp_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_ni     (por_ni),
  .res_valid_i(res_valid_i),
  .res_fault_i(res_fault_i),
  .req_o      (req_o),
  .lamp_no    (lamp_no),
  .hold_i     (hold_w)
);

// File: tb/rc5_lamp_ctrl_tb.sv
module rc5_lamp_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0, por_ni = 1'b0;
  logic       res_valid_i = 1'b0, res_fault_i = 1'b0;
  logic [4:0] res_sys_i = '0;
  logic [6:0] res_cmd_i = '0;
  logic       learn_ni = 1'b1;
  logic       req_o, lamp_no;
  int         n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  rc5_lamp_ctrl u_dut (.*);

  // {fault, learn_n, sys[4:0], cmd[6:0], expected lamp_no}
  localparam logic [14:0] VEC [16] = '{
    {1'b0, 1'b1, 5'd0, 7'h04, 1'b0},  // R2 default pair hit, lamp on
    {1'b0, 1'b1, 5'd0, 7'h04, 1'b0},  // R5 key held
    {1'b1, 1'b1, 5'd0, 7'h00, 1'b0},  // R5 release
    {1'b0, 1'b1, 5'd0, 7'h44, 1'b1},  // R3 toggle bit set still hits
    {1'b1, 1'b1, 5'd0, 7'h00, 1'b1},
    {1'b0, 1'b1, 5'd1, 7'h04, 1'b1},  // R4 system miss
    {1'b0, 1'b1, 5'd0, 7'h05, 1'b1},  // R4 command bit0 miss
    {1'b0, 1'b1, 5'd0, 7'h24, 1'b1},  // R3 bit5 compared
    {1'b0, 1'b0, 5'd3, 7'h49, 1'b0},  // R6 learn 3/9, toggles same frame
    {1'b1, 1'b1, 5'd0, 7'h00, 1'b0},
    {1'b0, 1'b1, 5'd0, 7'h04, 1'b0},  // R6 old pair gone
    {1'b0, 1'b1, 5'd3, 7'h09, 1'b1},  // R6 learned pair hits
    {1'b0, 1'b0, 5'd7, 7'h07, 1'b1},  // R7 learn in hold ignored
    {1'b1, 1'b1, 5'd0, 7'h00, 1'b1},
    {1'b0, 1'b1, 5'd7, 7'h07, 1'b1},  // R7 7/7 not stored
    {1'b0, 1'b1, 5'd3, 7'h09, 1'b0}   // R7 pair still 3/9
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2";
      1, 2, 4: return "R5";
      3, 7: return "R3";
      5, 6: return "R4";
      8, 9, 10, 11: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // apply learn level, let it pass the synchroniser, send one result
  task automatic send(input logic flt, input logic lrn_n, input logic [4:0] s, input logic [6:0] c);
    learn_ni = lrn_n;
    repeat (3) @(negedge clk_i);
    res_sys_i   = s;
    res_cmd_i   = c;
    res_valid_i = !flt;
    res_fault_i = flt;
    @(negedge clk_i);
    res_valid_i = 1'b0;
    res_fault_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 lamp in reset", lamp_no, 1'b1);
    check("R1 req in reset", req_o, 1'b1);
    rst_ni = 1'b1;
    por_ni = 1'b1;
    @(negedge clk_i);
    check("R10 req idle", req_o, 1'b0);
    check("R1 lamp after reset", lamp_no, 1'b1);

    for (int i = 0; i < 16; i++) begin
      send(VEC[i][14], VEC[i][13], VEC[i][12:8], VEC[i][7:1]);
      check(vec_tag(i), lamp_no, VEC[i][0]);
      check("R10 req after result", req_o, 1'b1);
    end
    @(negedge clk_i);
    check("R10 req single pulse", req_o, 1'b0);

    // ordinary reset: lamp off, learned 3/9 kept
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 lamp off in reset", lamp_no, 1'b1);
    rst_ni = 1'b1;
    send(1'b0, 1'b1, 5'd0, 7'h04);
    check("R9 default not restored", lamp_no, 1'b1);
    send(1'b0, 1'b1, 5'd3, 7'h09);
    check("R9 pair kept", lamp_no, 1'b0);

    // power-on reset: defaults 0/4 back
    por_ni = 1'b0;
    @(negedge clk_i);
    check("R1 lamp off in por", lamp_no, 1'b1);
    por_ni = 1'b1;
    send(1'b0, 1'b1, 5'd3, 7'h09);
    check("R8 learned pair cleared", lamp_no, 1'b1);
    send(1'b0, 1'b1, 5'd0, 7'h04);
    check("R8 default pair hits", lamp_no, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule